// File: doc/BRIEF.md
# Character Change Streaming Engine

This block keeps a serially attached on-screen-display device in step with a character frame held on chip. It compares a working frame buffer with a shadow copy of what the device is known to show. For every cell that differs it emits a six-byte sequence of register writes on a byte-wide valid/ready stream, and that stream feeds an SPI master. Once the last byte of a cell's sequence is taken, the block copies the working character into the shadow buffer. Only changed cells therefore cost link bandwidth.

Each start pulse runs one bounded pass. The pass examines at most a fixed window of positions, and a persistent cursor lets the next pass resume where this one stopped. The cursor wraps to zero at the end of the active screen, and the wrap ends the pass early. The screen size follows a PAL/NTSC select that is captured when the pass starts. A shadow-clear request zeroes the whole shadow buffer one entry per cycle, which forces a full redraw on the following passes.

Both buffers sit outside the block. They share one read address, return data in the same cycle, and the block drives a write port into the shadow buffer.

Top module: `ccs_top`

## Requirements
- R1: While reset is held and after it is released, `out_valid_o`, `done_o` and `shd_we_o` are low until a start or clear request arrives.
- R2: For a changed cell at position p, the stream carries exactly six bytes in this order: 0x05, p[15:8], 0x06, p[7:0], 0x07, then the working character. p is zero-extended to 16 bits, so cells 256 and above give a high byte of 0x01.
- R3: In the cycle the sixth byte of a cell is accepted, `shd_we_o` is high, and `shd_waddr_o`/`shd_wdata_o` carry that cell's position and character. Afterwards the shadow buffer equals the working buffer at every visited cell.
- R4: One pass examines no more than 100 positions (parameter WINDOW).
- R5: The cursor keeps its value between passes. When it steps past the last cell of the active screen it returns to 0, and that pass ends at once.
- R6: With `pal_mode_i`=1 the active screen is 480 cells (16 rows of 30), and with 0 it is 390 cells (13 rows of 30). The mode is sampled with the start pulse. A cursor at or beyond the active size when a pass starts begins that pass at cell 0.
- R7: Every pass ends with a single-cycle `done_o` pulse. `done_o` is never high together with `out_valid_o`. A pass that finds no difference raises `done_o` without emitting any byte.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays unchanged, so no byte is lost or repeated.
- R9: A clear request seen while idle writes 0x00 to all 480 shadow entries, one per cycle, and emits no byte. Clear takes precedence over a start in the same cycle, and starts during the clear are ignored.
- R10: A start pulse that arrives while a pass is in progress has no effect on the byte stream of that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Pulse: run one scan pass |
| clear_i | input | 1 | Pulse: zero the shadow buffer |
| pal_mode_i | input | 1 | 1 = 480-cell screen, 0 = 390-cell screen |
| rd_addr_o | output | 9 | Shared read address into both buffers |
| wrk_data_i | input | 8 | Working buffer character at `rd_addr_o` |
| shd_data_i | input | 8 | Shadow buffer character at `rd_addr_o` |
| shd_we_o | output | 1 | Shadow buffer write enable |
| shd_waddr_o | output | 9 | Shadow buffer write address |
| shd_wdata_o | output | 8 | Shadow buffer write data |
| out_data_o | output | 8 | Stream byte |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Stream sink ready |
| done_o | output | 1 | Single-cycle end-of-pass pulse |

## Verification
The properties assume the two buffers answer a read in the same cycle. They also assume the shadow buffer takes a write at the clock edge where `shd_we_o` is high, so a written cell reads back new data on the next visit. The bench models both buffers as plain arrays with exactly that behaviour. It changes the mode only between passes, and the stalls it applies on `out_ready_i` vary from none to long runs, which keeps every handshake within the valid/ready rules the hold property relies on.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_SCAN  = 2'd2,
    ST_EMIT  = 2'd3
  } ccs_state_e;

  localparam logic [7:0] CODE_POS_HI = 8'h05;
  localparam logic [7:0] CODE_POS_LO = 8'h06;
  localparam logic [7:0] CODE_CHAR   = 8'h07;
  localparam int         SEQ_LEN     = 6;
endpackage

// File: rtl/ccs_cursor.sv
module ccs_cursor #(
  parameter int POS_W  = 9,
  parameter int CNT_W  = 7,
  parameter int WINDOW = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [POS_W:0]   size_i,
  output logic [POS_W-1:0] pos_o,
  output logic             end_o
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [POS_W:0]   pos_inc;
  logic [CNT_W:0]   cnt_inc;
  logic             wrap, full, en;

  assign pos_inc = {1'b0, pos_q} + 1'b1;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign wrap    = pos_inc >= size_i;
  assign full    = cnt_inc == (CNT_W+1)'(WINDOW);
  assign end_o   = wrap | full;
  assign pos_o   = pos_q;
  assign en      = load_i | step_i;

  always_comb begin
    pos_d = pos_q;
    cnt_d = cnt_q;
    if (load_i) begin
      pos_d = ({1'b0, pos_q} >= size_i) ? '0 : pos_q;
      cnt_d = '0;
    end else if (step_i) begin
      pos_d = wrap ? '0 : pos_inc[POS_W-1:0];
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      pos_q <= pos_d;
      cnt_q <= cnt_d;
    end
  end

  // R4: a step never happens once the window is used up
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cnt_q < CNT_W'(WINDOW)));
  // R5/R6: the cursor stays inside the active screen while stepping
  p_pos_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ({1'b0, pos_q} < size_i));
endmodule

// File: rtl/ccs_emit.sv
module ccs_emit
  import ccs_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       char_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             last_o,
  output logic [POS_W-1:0] pos_o,
  output logic [7:0]       char_o
);
  localparam int PAD = 16 - POS_W;

  logic [POS_W-1:0] pos_q, pos_d;
  logic [7:0]       char_q, char_d;
  logic [2:0]       idx_q, idx_d;
  logic             valid_q, valid_d, en;
  logic [15:0]      addr_w;

  assign addr_w  = {{PAD{1'b0}}, pos_q};
  assign en      = capture_i | (valid_q & ready_i);
  assign last_o  = valid_q & ready_i & (idx_q == 3'(SEQ_LEN-1));
  assign valid_o = valid_q;
  assign pos_o   = pos_q;
  assign char_o  = char_q;

  always_comb begin
    unique case (idx_q)
      3'd0:    data_o = CODE_POS_HI;
      3'd1:    data_o = addr_w[15:8];
      3'd2:    data_o = CODE_POS_LO;
      3'd3:    data_o = addr_w[7:0];
      3'd4:    data_o = CODE_CHAR;
      default: data_o = char_q;
    endcase
  end

  always_comb begin
    pos_d   = pos_q;
    char_d  = char_q;
    idx_d   = idx_q;
    valid_d = valid_q;
    if (capture_i) begin
      pos_d   = pos_i;
      char_d  = char_i;
      idx_d   = '0;
      valid_d = 1'b1;
    end else if (last_o) begin
      idx_d   = '0;
      valid_d = 1'b0;
    end else if (valid_q && ready_i) begin
      idx_d   = idx_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      char_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (en) begin
      pos_q   <= pos_d;
      char_q  <= char_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  // R8: a stalled byte is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_o)));
  // R2: every sequence opens with the high-address code
  p_first_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> (data_o == CODE_POS_HI));
  // R8: a new cell is never captured over a sequence in flight
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |-> !valid_q);
endmodule

// File: rtl/ccs_top.sv
module ccs_top
  import ccs_pkg::*;
#(
  parameter int COLS      = 30,
  parameter int ROWS_PAL  = 16,
  parameter int ROWS_NTSC = 13,
  parameter int WINDOW    = 100,
  parameter int POS_W     = $clog2(COLS*ROWS_PAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             pal_mode_i,
  output logic [POS_W-1:0] rd_addr_o,
  input  logic [7:0]       wrk_data_i,
  input  logic [7:0]       shd_data_i,
  output logic             shd_we_o,
  output logic [POS_W-1:0] shd_waddr_o,
  output logic [7:0]       shd_wdata_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             done_o
);
  localparam int CELLS_PAL  = COLS * ROWS_PAL;
  localparam int CELLS_NTSC = COLS * ROWS_NTSC;
  localparam int CNT_W      = $clog2(WINDOW + 1);
  localparam logic [POS_W:0]   SIZE_PAL  = (POS_W+1)'(CELLS_PAL);
  localparam logic [POS_W:0]   SIZE_NTSC = (POS_W+1)'(CELLS_NTSC);
  localparam logic [POS_W-1:0] CLR_LAST  = POS_W'(CELLS_PAL - 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ccs_state_e       state_q, state_d;
  logic             mode_q, mode_d;
  logic [POS_W-1:0] clr_q, clr_d;
  logic             done_q, done_d;
  logic             load, step, capture, cur_end, emit_last, differ;
  logic [POS_W:0]   size_sel;
  logic [POS_W-1:0] cur_pos, emit_pos;
  logic [7:0]       emit_char;

  assign size_sel = (state_q == ST_IDLE) ? (pal_mode_i ? SIZE_PAL : SIZE_NTSC)
                                         : (mode_q     ? SIZE_PAL : SIZE_NTSC);
  assign differ   = wrk_data_i != shd_data_i;

  ccs_cursor #(.POS_W(POS_W), .CNT_W(CNT_W), .WINDOW(WINDOW)) u_cursor (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (load),
    .step_i (step),
    .size_i (size_sel),
    .pos_o  (cur_pos),
    .end_o  (cur_end)
  );

  ccs_emit #(.POS_W(POS_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .capture_i (capture),
    .pos_i     (cur_pos),
    .char_i    (wrk_data_i),
    .ready_i   (out_ready_i),
    .valid_o   (out_valid_o),
    .data_o    (out_data_o),
    .last_o    (emit_last),
    .pos_o     (emit_pos),
    .char_o    (emit_char)
  );

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    clr_d   = clr_q;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (clear_i) begin
          state_d = ST_CLEAR;
          clr_d   = '0;
        end else if (start_i) begin
          state_d = ST_SCAN;
          mode_d  = pal_mode_i;
          load    = 1'b1;
        end
      end
      ST_CLEAR: begin
        clr_d = clr_q + 1'b1;
        if (clr_q == CLR_LAST) state_d = ST_IDLE;
      end
      ST_SCAN: begin
        if (differ) begin
          capture = 1'b1;
          state_d = ST_EMIT;
        end else begin
          step = 1'b1;
          if (cur_end) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: begin
        if (emit_last) begin
          step = 1'b1;
          if (cur_end) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_SCAN;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      clr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      clr_q   <= clr_d;
      done_q  <= done_d;
    end
  end

  assign rd_addr_o   = cur_pos;
  assign done_o      = done_q;
  assign shd_we_o    = (state_q == ST_CLEAR) | emit_last;
  assign shd_waddr_o = (state_q == ST_CLEAR) ? clr_q : emit_pos;
  assign shd_wdata_o = (state_q == ST_CLEAR) ? 8'h00 : emit_char;

  // R9: nothing is streamed while the shadow is being cleared
  p_quiet_clear_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_CLEAR) |-> !out_valid_o);
  // R7: end-of-pass pulse never overlaps a byte
  p_done_silent_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !out_valid_o);
  // R7: the pulse lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);
  // R3: a scan-time shadow write coincides with acceptance of the character byte
  p_shadow_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shd_we_o && state_q != ST_CLEAR) |-> (out_valid_o && out_ready_i && out_data_o == shd_wdata_o));
endmodule

// File: tb/ccs_top_bench.sv
`timescale 1ns/1ps
module ccs_top_bench;
  localparam int NCELL = 480;
  localparam int NV    = 5;
  // {pal, ready mode, char, second pos, first pos}
  localparam logic [28:0] VEC [NV] = '{
    29'({1'b1, 2'd0, 8'h41, 9'd300, 9'd5}),
    29'({1'b1, 2'd1, 8'hFF, 9'd479, 9'd256}),
    29'({1'b0, 2'd2, 8'h10, 9'd389, 9'd120}),
    29'({1'b0, 2'd3, 8'h7E, 9'd200, 9'd0}),
    29'({1'b1, 2'd2, 8'h33, 9'd420, 9'd390})
  };

  logic       clk = 1'b0;
  logic       rst_n, start_i, clear_i, pal_mode_i, out_ready_i;
  logic [8:0] rd_addr_o, shd_waddr_o;
  logic [7:0] wrk_data_i, shd_data_i, shd_wdata_o, out_data_o;
  logic       shd_we_o, out_valid_o, done_o;

  logic [7:0] wrk_mem [NCELL];
  logic [7:0] shd_mem [NCELL];
  logic [7:0] ref_shd [NCELL];
  logic [7:0] exp_b [1024];
  logic [7:0] got_b [1024];
  int exp_n, m_cur, total, bad, cyc;

  always #2.5 clk = ~clk;

  assign wrk_data_i = (rd_addr_o < 9'(NCELL)) ? wrk_mem[rd_addr_o] : 8'h00;
  assign shd_data_i = (rd_addr_o < 9'(NCELL)) ? shd_mem[rd_addr_o] : 8'h00;
  always @(posedge clk) if (shd_we_o && shd_waddr_o < 9'(NCELL)) shd_mem[shd_waddr_o] <= shd_wdata_o;

  ccs_top u_ccs_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .pal_mode_i(pal_mode_i), .rd_addr_o(rd_addr_o), .wrk_data_i(wrk_data_i),
    .shd_data_i(shd_data_i), .shd_we_o(shd_we_o), .shd_waddr_o(shd_waddr_o),
    .shd_wdata_o(shd_wdata_o), .out_data_o(out_data_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit rdy_bit(input int mode, input int k);
    case (mode)
      0:       return 1'b1;
      1:       return k[0];
      2:       return ((k * 37) >> 3) % 2 == 1;
      default: return (k % 8) == 7;
    endcase
  endfunction

  // expected stream from the requirements: R2 bytes, R4 window, R5 wrap, R6 size
  task automatic model_pass(input bit pal);
    int size, cnt, p;
    size = pal ? 480 : 390;
    if (m_cur >= size) m_cur = 0;
    cnt = 0; exp_n = 0;
    forever begin
      p = m_cur;
      if (wrk_mem[p] != ref_shd[p]) begin
        exp_b[exp_n]   = 8'h05; exp_b[exp_n+1] = 8'(p >> 8);
        exp_b[exp_n+2] = 8'h06; exp_b[exp_n+3] = 8'(p);
        exp_b[exp_n+4] = 8'h07; exp_b[exp_n+5] = wrk_mem[p];
        exp_n += 6;
        ref_shd[p] = wrk_mem[p];
      end
      cnt++;
      if (p + 1 >= size) begin m_cur = 0; break; end
      m_cur = p + 1;
      if (cnt == 100) break;
    end
  endtask

  task automatic run_pass(input string tag, input bit pal, input int rmode, input bit extra);
    int n, serr, bad_i;
    bit stalled, got_done;
    logic [7:0] pd;
    model_pass(pal);
    n = 0; serr = 0; stalled = 1'b0; got_done = 1'b0; pd = 8'h00; bad_i = -1;
    @(negedge clk); pal_mode_i = pal; start_i = 1'b1; out_ready_i = 1'b0;
    for (int k = 0; k < 12000; k++) begin
      @(negedge clk);
      start_i = extra && (k == 3);
      out_ready_i = rdy_bit(rmode, k);
      #1;
      if (stalled && (!out_valid_o || out_data_o != pd)) serr++;
      stalled = out_valid_o && !out_ready_i;
      pd = out_data_o;
      if (out_valid_o && out_ready_i) begin
        if (n < 1024) got_b[n] = out_data_o;
        n++;
      end
      if (done_o) begin got_done = 1'b1; break; end
    end
    start_i = 1'b0;
    check(got_done && n == exp_n, tag, "byte count at done", n, exp_n);
    for (int i = 0; i < exp_n && i < n; i++)
      if (bad_i < 0 && got_b[i] != exp_b[i]) bad_i = i;
    check(bad_i < 0, tag, "stream byte",
          (bad_i < 0) ? 0 : int'(got_b[bad_i]), (bad_i < 0) ? 0 : int'(exp_b[bad_i]));
    if (rmode != 0) check(serr == 0, "R8", "stall hold errors", serr, 0);
  endtask

  task automatic check_shadow(input string tag);
    int diff = 0;
    for (int i = 0; i < NCELL; i++) if (shd_mem[i] != ref_shd[i]) diff++;
    check(diff == 0, tag, "shadow cells differing", diff, 0);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        bad++; total++;
        $display("FAIL R7 watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int wcount, werr, verr;
    total = 0; bad = 0; m_cur = 0;
    rst_n = 1'b0; start_i = 1'b0; clear_i = 1'b0; pal_mode_i = 1'b1; out_ready_i = 1'b0;
    for (int i = 0; i < NCELL; i++) begin
      wrk_mem[i] = 8'h20; shd_mem[i] = 8'h00; ref_shd[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid_o && !done_o && !shd_we_o, "R1", "outputs in reset", int'(out_valid_o) + int'(done_o) + int'(shd_we_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check(!out_valid_o && !done_o && !shd_we_o, "R1", "outputs after release", int'(out_valid_o) + int'(done_o) + int'(shd_we_o), 0);

    // table of vectors: edits, mode and back-pressure pattern (R2 R3 R4 R5 R8)
    for (int v = 0; v < NV; v++) begin
      wrk_mem[VEC[v][8:0]]  = VEC[v][25:18];
      wrk_mem[VEC[v][17:9]] = VEC[v][25:18] ^ 8'h5A;
      for (int p = 0; p < 6; p++) run_pass("R2", VEC[v][28], int'(VEC[v][27:26]), 1'b0);
      check_shadow("R3");
    end

    // converge on the full screen, then a pass with nothing to send (R7)
    for (int p = 0; p < 6; p++) run_pass("R4", 1'b1, 0, 1'b0);
    run_pass("R7", 1'b1, 0, 1'b0);
    check(exp_n == 0, "R7", "model bytes on idle pass", exp_n, 0);

    // shadow clear with a start in the same cycle (R9)
    @(negedge clk); clear_i = 1'b1; start_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    wcount = 0; werr = 0; verr = 0;
    for (int k = 0; k < 520; k++) begin
      #1;
      if (shd_we_o) begin wcount++; if (shd_wdata_o != 8'h00) werr++; end
      if (out_valid_o || done_o) verr++;
      @(negedge clk);
      start_i = (k == 40);
    end
    start_i = 1'b0;
    for (int i = 0; i < NCELL; i++) ref_shd[i] = 8'h00;
    check(wcount == 480, "R9", "clear writes", wcount, 480);
    check(werr == 0 && verr == 0, "R9", "nonzero writes or stream activity", werr + verr, 0);
    check_shadow("R9");

    // second start in the middle of a redraw pass (R10)
    run_pass("R10", 1'b1, 1, 1'b1);

    // move cursor beyond 390, then switch to the smaller screen (R6)
    for (int p = 0; p < 12 && m_cur < 390; p++) run_pass("R5", 1'b1, 0, 1'b0);
    check(m_cur >= 390, "R6", "model cursor before switch", m_cur, 390);
    wrk_mem[0] = 8'h5C;
    run_pass("R6", 1'b0, 0, 1'b0);
    check(got_b[3] == 8'h00, "R6", "first cell after switch", int'(got_b[3]), 0);
    for (int p = 0; p < 5; p++) run_pass("R5", 1'b0, 2, 1'b0);
    check_shadow("R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule